// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits in a single-wire bus transceiver between the host's transmit line and the enable of the low-side bus driver. While the guard is armed and the transceiver is in normal mode, a low transmit level pulls the bus dominant and a high level releases it recessive. A counter measures how long the driver has been held dominant without a break. When that time reaches a limit, the driver is forced recessive and a timeout flag is raised. This keeps a stuck host from blocking the bus.

The driver is never armed on its own. It comes out of reset disarmed, it is disarmed on every exit from normal mode, and it is disarmed after a timeout. To re-arm it, the synchronised transmit level must stay high for a qualified number of consecutive cycles while the transceiver is in normal mode. As a result, a transmit line that is held low, or left floating at its pulled-down low, through a mode change never reaches the bus. The timeout flag stays set until the next arming. All times are parameters counted in clock cycles.

Top module: `txd_dom_guard`

## Requirements
- R1: While reset is asserted and after it is released, `drv_dom_o` and `tmo_o` are 0 and the guard is disarmed. The transmit synchroniser resets to low, so a floating transmit input is treated as low.
- R2: `drv_dom_o` is 1 only while `normal_i` is 1. It drops in the same cycle that `normal_i` falls, and that exit disarms the guard.
- R3: While the guard is armed, `drv_dom_o` is the inverse of `tx_i` delayed by the two-flop synchroniser: tx low gives 1 (dominant) and tx high gives 0 (recessive).
- R4: Arming requires the synchronised transmit level to be high in normal mode for `REL_CYC` consecutive cycles. A high period of `REL_CYC-1` cycles does not arm the guard.
- R5: Qualification starts again from zero at every entry into normal mode. A transmit held low through the entry produces no dominant cycle, and high time seen outside normal mode does not count.
- R6: `drv_dom_o` stays 1 for at most `TOUT_CYC` consecutive cycles. A low lasting `TOUT_CYC` cycles or longer gives exactly `TOUT_CYC` dominant cycles, then disarms the guard and sets `tmo_o`. A low of `TOUT_CYC-1` cycles does not set `tmo_o`.
- R7: `tmo_o` stays 1, and the driver stays recessive, until a new qualified high period re-arms the guard. `tmo_o` clears on that arming.
- R8: While the guard is armed, short high periods between dominant bits do not disarm it. The total number of dominant cycles equals the total number of low transmit cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_i | input | 1 | Raw host transmit level (0 = dominant request) |
| normal_i | input | 1 | Transceiver is in normal mode |
| drv_dom_o | output | 1 | Command to pull the bus dominant |
| tmo_o | output | 1 | Dominant timeout has tripped and the guard is not yet re-armed |

## Verification
The bench measures the arming threshold from both sides. A high of `REL_CYC-1` cycles must give no dominant cycle and a high of `REL_CYC` cycles must arm the guard, so a qualifier that is off by one, or that skips the synchroniser latency, fails. It also drives a low of `TOUT_CYC-1` cycles and one far longer than `TOUT_CYC`. The first exposes a timer that trips early. The second exposes a timer that trips late, or a driver that is never released. Mode entries are tested with transmit held low and with transmit already high. A design that keeps the arming across a mode exit, or that counts high time seen outside normal mode, would drive the bus too early. Finally, the bench checks that the timeout flag survives a high that is too short and clears only when the guard re-arms.

// File: rtl/txg_pkg.sv
// Shared types for the transmit dominant timeout guard.
package txg_pkg;

    // Guard state: waiting for a qualified high, armed, or tripped by timeout.
    typedef enum logic [1:0] {
        GS_HOLD = 2'd0,
        GS_LIVE = 2'd1,
        GS_TRIP = 2'd2
    } guard_state_t;

    // Width of a counter that must represent values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

endpackage

// File: rtl/txg_sync.sv
// Multi-flop synchroniser for the asynchronous transmit level.
// Assumes STAGES >= 2. Resets to low so that an open input reads as low.
module txg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/txg_hi_qual.sv
// High-time qualifier: counts consecutive cycles with the transmit level
// high while enabled, and flags the cycle that completes REL_CYC of them.
// Assumes REL_CYC >= 1. Any low or disable restarts the count.
module txg_hi_qual
    import txg_pkg::*;
#(
    parameter int unsigned REL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tx_s_i,
    output logic qual_o
);
    localparam int unsigned CW = cnt_width(REL_CYC);
    localparam logic [CW-1:0] LAST = CW'(REL_CYC - 1);

    logic [CW-1:0] hi_cnt_q;
    logic          hi_now;

    assign hi_now = en_i & tx_s_i;
    assign qual_o = hi_now & (hi_cnt_q == LAST);

    // Count the high run, holding at LAST until the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!hi_now) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != LAST) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    // R4
    hi_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q <= LAST);
endmodule

// File: rtl/txg_dom_timer.sv
// Dominant timer: counts consecutive cycles in which the driver is
// dominant and flags the cycle that completes TOUT_CYC of them.
// Assumes TOUT_CYC >= 2. The count restarts as soon as the driver releases.
module txg_dom_timer
    import txg_pkg::*;
#(
    parameter int unsigned TOUT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_i,
    output logic expire_o
);
    localparam int unsigned CW = cnt_width(TOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TOUT_CYC - 1);

    logic [CW-1:0] lo_cnt_q;

    assign expire_o = dom_i & (lo_cnt_q == LAST);

    // Advance while dominant; clear on release or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
        end else if (!dom_i || expire_o) begin
            lo_cnt_q <= '0;
        end else begin
            lo_cnt_q <= lo_cnt_q + 1'b1;
        end
    end

    // R6
    lo_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt_q <= LAST);
endmodule

// File: rtl/txd_dom_guard.sv
// Transmit dominant timeout guard. It gates the bus driver with an arming
// state that requires a qualified high on transmit, and disarms it on a
// mode exit or after a dominant run of TOUT_CYC cycles.
// Assumes tx_i is asynchronous and normal_i is synchronous to clk.
module txd_dom_guard
    import txg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REL_CYC     = 8,
    parameter int unsigned TOUT_CYC    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_i,
    input  logic normal_i,
    output logic drv_dom_o,
    output logic tmo_o
);
    guard_state_t state_q;
    guard_state_t state_d;
    logic         tx_s;
    logic         qual;
    logic         expire;
    logic         live;

    txg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tx_i),
        .q_o   (tx_s)
    );

    txg_hi_qual #(.REL_CYC(REL_CYC)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (normal_i),
        .tx_s_i (tx_s),
        .qual_o (qual)
    );

    txg_dom_timer #(.TOUT_CYC(TOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .dom_i    (drv_dom_o),
        .expire_o (expire)
    );

    assign live      = (state_q == GS_LIVE);
    assign drv_dom_o = live & normal_i & ~tx_s;
    assign tmo_o     = (state_q == GS_TRIP);

    // Next-state logic for arming, mode exit and timeout.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HOLD: if (qual) state_d = GS_LIVE;
            GS_LIVE: begin
                if (!normal_i)   state_d = GS_HOLD;
                else if (expire) state_d = GS_TRIP;
            end
            GS_TRIP: if (qual) state_d = GS_LIVE;
            default: state_d = GS_HOLD;
        endcase
    end

    // Guard state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_HOLD;
        else        state_q <= state_d;
    end

    // R2
    leave_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !normal_i) |=> !live);

    // R4
    arm_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> $past(qual));

    // R6
    trip_after_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_o) |-> $past(drv_dom_o));

    // R7
    trip_clears_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_o) |-> live);
endmodule

// File: tb/txd_dom_guard_tb.sv
// Directed bench for the transmit dominant timeout guard.
module txd_dom_guard_tb;
    localparam int REL  = 8;
    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_i;
    logic normal_i;
    logic drv_dom_o;
    logic tmo_o;

    int n_chk  = 0;
    int n_fail = 0;
    int dom_cnt;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txd_dom_guard #(.SYNC_STAGES(2), .REL_CYC(REL), .TOUT_CYC(TOUT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_i      (tx_i),
        .normal_i  (normal_i),
        .drv_dom_o (drv_dom_o),
        .tmo_o     (tmo_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Hold tx at a level for n cycles and count the dominant cycles seen.
    task automatic drive(input logic lvl, input int n);
        tx_i = lvl;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (drv_dom_o) dom_cnt++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tx_i = 1'b0; normal_i = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check("R1 drv in reset", drv_dom_o, 0);
        check("R1 tmo in reset", tmo_o, 0);
        rst_n = 1'b1;
        dom_cnt = 0;
        drive(1'b0, 60);
        check("R5 low after reset dom cycles", dom_cnt, 0);
        check("R1 tmo after reset", tmo_o, 0);
    endtask

    task automatic t_short_high();
        dom_cnt = 0;
        drive(1'b1, REL - 1);
        drive(1'b0, 20);
        check("R4 high REL-1 dom cycles", dom_cnt, 0);
    endtask

    task automatic t_arm();
        dom_cnt = 0;
        drive(1'b1, REL);
        drive(1'b0, 20);
        drive(1'b1, 4);
        check("R4 R3 high REL then low 20 dom cycles", dom_cnt, 20);
        check("R3 recessive after high", drv_dom_o, 0);
        check("R6 no tmo short low", tmo_o, 0);
    endtask

    task automatic t_pattern();
        int lows[5] = '{3, 7, 1, 12, 5};
        dom_cnt = 0;
        foreach (lows[k]) begin
            drive(1'b0, lows[k]);
            drive(1'b1, 2);
        end
        drive(1'b1, 3);
        check("R8 bit pattern dom cycles", dom_cnt, 28);
        check("R8 no tmo in pattern", tmo_o, 0);
    endtask

    task automatic t_edge_low();
        dom_cnt = 0;
        drive(1'b0, TOUT - 1);
        drive(1'b1, 4);
        check("R6 low TOUT-1 dom cycles", dom_cnt, TOUT - 1);
        check("R6 low TOUT-1 no tmo", tmo_o, 0);
    endtask

    task automatic t_timeout();
        dom_cnt = 0;
        drive(1'b0, TOUT + 25);
        check("R6 long low dom cycles", dom_cnt, TOUT);
        check("R6 tmo set", tmo_o, 1);
        dom_cnt = 0;
        drive(1'b1, REL - 1);
        drive(1'b0, 10);
        check("R7 short high after trip dom cycles", dom_cnt, 0);
        check("R7 tmo held", tmo_o, 1);
        drive(1'b1, REL + 2);
        check("R7 tmo cleared on arm", tmo_o, 0);
        dom_cnt = 0;
        drive(1'b0, 10);
        drive(1'b1, 4);
        check("R7 rearmed dom cycles", dom_cnt, 10);
    endtask

    task automatic t_mode();
        drive(1'b0, 5);
        check("R3 dominant while armed", drv_dom_o, 1);
        normal_i = 1'b0;
        #1;
        check("R2 drop on mode exit", drv_dom_o, 0);
        dom_cnt = 0;
        drive(1'b0, 5);
        normal_i = 1'b1;
        drive(1'b0, 30);
        check("R5 low through entry dom cycles", dom_cnt, 0);
        // Entry with tx already high: history outside normal is ignored.
        normal_i = 1'b0;
        drive(1'b1, 20);
        normal_i = 1'b1;
        dom_cnt = 0;
        drive(1'b1, REL - 3);
        drive(1'b0, 10);
        check("R5 high short of REL after entry dom cycles", dom_cnt, 0);
        normal_i = 1'b0;
        drive(1'b1, 20);
        normal_i = 1'b1;
        dom_cnt = 0;
        drive(1'b1, REL - 2);
        drive(1'b0, 6);
        drive(1'b1, 4);
        check("R2 R5 rearm after entry dom cycles", dom_cnt, 6);
    endtask

    initial begin
        t_reset();
        t_short_high();
        drive(1'b0, 4);
        t_arm();
        t_pattern();
        t_edge_low();
        t_timeout();
        t_mode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule